// File: doc/BRIEF.md
# Geometry Vertex Emit Buffer

This unit serves the vertex output path of a geometry-shading stage. It watches a stream of 32-bit instruction words and acts on two of them. The slot-select instruction records which of four vertex slots the next emit targets, and a two-bit primitive flag. The emit instruction copies the current output-register set into that slot. The output-register set is eight 64-bit vectors, flattened into one word. If the recorded primitive flag is nonzero, the emit also raises a primitive made of slots 0, 1 and 2, in that order, on a valid/ready output.

Reset clears the four slots, and nothing clears them afterwards. A strip or fan can therefore rewrite one slot and send a new triangle that reuses the two older vertices. An emit needs its own slot-select: an emit with no slot-select since reset or since the previous emit sets a sticky error flag and changes nothing else.

Both streams use valid/ready. An instruction is taken on a clock edge where `instr_valid` and `instr_ready` are both high. A primitive is taken on a clock edge where `prim_valid` and `prim_ready` are both high. While a primitive is waiting and `prim_ready` is low, the unit holds the primitive steady and drops `instr_ready`. An upstream sender must keep its word until it is taken.

Top module: `gs_emit_unit`

## Requirements
- R1: After reset, `prim_valid` and `err_flag` are 0, `instr_ready` is 1, and every slot reads as zero.
- R2: A word with bits [31:26] = 0x2B is a slot-select. Bits [25:24] give the slot and bits [23:22] give the primitive flag. All other bits are ignored.
- R3: A taken word with bits [31:26] = 0x2A is an emit. An emit writes `out_regs`, as sampled on the accepting edge, into the selected slot. A write to slot 3 changes none of slots 0 to 2.
- R4: A valid emit with a nonzero flag sets `prim_valid` in the cycle after the accepting edge. A valid emit with a zero flag does not set it.
- R5: `prim_data` carries slot k at bits [k*512 +: 512] for k = 0, 1, 2. It shows the slot contents after the triggering write.
- R6: A primitive handshake leaves every slot unchanged. Later primitives reuse any slot that has not been rewritten.
- R7: While `prim_valid` is 1 and `prim_ready` is 0, `prim_valid` stays 1 and `prim_data` stays stable.
- R8: `instr_ready` is 0 exactly when `prim_valid` is 1 and `prim_ready` is 0.
- R9: An emit with no slot-select since reset or since the previous emit sets `err_flag`, which stays set until reset. That emit writes no slot and raises no primitive.
- R10: Words with any other opcode change no slot, no pending selection and no output.
- R11: When several slot-selects come before one emit, the emit uses the most recent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Instruction word can be taken |
| instr_word | input | 32 | Instruction word |
| out_regs | input | 512 | Output registers o0..o7, with o(i) at [i*64 +: 64] |
| prim_valid | output | 1 | Primitive offered |
| prim_ready | input | 1 | Downstream takes the primitive |
| prim_data | output | 1536 | Slots 0, 1 and 2 of the buffer |
| err_flag | output | 1 | Sticky flag for an emit with no slot-select |

## Verification
Between the accepting edge of an emit and its results there is one register stage. The slot contents, `prim_valid` and `err_flag` all change on the accepting edge itself. They are therefore first seen at the next falling edge. `instr_ready` and the stall follow `prim_ready` and `prim_valid` in the same cycle. The driver changes inputs just after a rising edge and predicts the primitive at the falling edge where it sees the word taken. The monitor compares a primitive at a falling edge where valid and ready are both high, which is the cycle before the handshake edge. Each check therefore samples a value that is already settled.

// File: rtl/gs_emit_pkg.sv
package gs_emit_pkg;
  localparam logic [5:0] OPC_EMIT    = 6'h2A;
  localparam logic [5:0] OPC_SETSLOT = 6'h2B;
  localparam int OPC_LSB   = 26;
  localparam int SLOT_LSB  = 24;
  localparam int PFLAG_LSB = 22;
  localparam int SLOT_W    = 2;
  localparam int PFLAG_W   = 2;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_SET  = 2'd1,
    CMD_EMIT = 2'd2
  } emit_cmd_e;

  typedef struct packed {
    emit_cmd_e            cmd;
    logic [SLOT_W-1:0]    slot;
    logic [PFLAG_W-1:0]   pflag;
  } emit_dec_t;
endpackage

// File: rtl/gs_emit_decode.sv
module gs_emit_decode
  import gs_emit_pkg::*;
(
  input  logic [31:0] word,
  output emit_dec_t   dec
);
  logic [5:0] opc;
  logic       unused_low;

  assign opc        = word[OPC_LSB +: 6];
  assign unused_low = ^word[PFLAG_LSB-1:0];

  always_comb begin
    dec.slot  = word[SLOT_LSB +: SLOT_W];
    dec.pflag = word[PFLAG_LSB +: PFLAG_W];
    unique case (opc)
      OPC_SETSLOT: dec.cmd = CMD_SET;
      OPC_EMIT:    dec.cmd = CMD_EMIT;
      default:     dec.cmd = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/gs_emit_ctrl.sv
module gs_emit_ctrl
  import gs_emit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  emit_dec_t         dec,
  input  logic              prim_ready,
  output logic              instr_ready,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              prim_valid,
  output logic              err_flag
);
  logic               armed_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [PFLAG_W-1:0] pflag_q;
  logic               emit_cmd;

  assign emit_cmd    = fire && (dec.cmd == CMD_EMIT);
  assign instr_ready = !prim_valid || prim_ready;
  assign wr_en       = emit_cmd && armed_q;
  assign wr_slot     = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      slot_q     <= '0;
      pflag_q    <= '0;
      prim_valid <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (prim_valid && prim_ready) prim_valid <= 1'b0;
      if (fire && dec.cmd == CMD_SET) begin
        armed_q <= 1'b1;
        slot_q  <= dec.slot;
        pflag_q <= dec.pflag;
      end else if (emit_cmd) begin
        if (armed_q) begin
          armed_q <= 1'b0;
          if (pflag_q != '0) prim_valid <= 1'b1;
        end else begin
          err_flag <= 1'b1;
        end
      end
    end
  end

  // R4
  prim_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pflag_q != '0) |=> prim_valid);

  // R7
  prim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_valid && !prim_ready) |=> prim_valid);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_cmd && !armed_q) |=> err_flag);
endmodule

// File: rtl/gs_emit_vbuf.sv
module gs_emit_vbuf
  import gs_emit_pkg::*;
#(
  parameter int VERT_W     = 512,
  parameter int PRIM_VERTS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  logic [VERT_W-1:0]            wr_data,
  output logic [PRIM_VERTS*VERT_W-1:0] prim_data
);
  logic [VERT_W-1:0] slot_mem [NUM_SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) slot_mem[s] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (wr_slot == SLOT_W'(s)) slot_mem[s] <= wr_data;
    end
  end

  for (genvar p = 0; p < PRIM_VERTS; p++) begin : g_prim
    assign prim_data[p*VERT_W +: VERT_W] = slot_mem[p];
  end

  // R3
  slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_mem[$past(wr_slot)] == $past(wr_data));

  // R6
  slot_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prim_data));
endmodule

// File: rtl/gs_emit_unit.sv
module gs_emit_unit
  import gs_emit_pkg::*;
#(
  parameter int VEC_W      = 64,
  parameter int NUM_OUT    = 8,
  parameter int PRIM_VERTS = 3,
  localparam int VERT_W    = VEC_W * NUM_OUT,
  localparam int PRIM_W    = PRIM_VERTS * VERT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  input  logic [VERT_W-1:0] out_regs,
  output logic              prim_valid,
  input  logic              prim_ready,
  output logic [PRIM_W-1:0] prim_data,
  output logic              err_flag
);
  emit_dec_t         dec;
  logic              fire;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;

  assign fire = instr_valid && instr_ready;

  gs_emit_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  gs_emit_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .dec         (dec),
    .prim_ready  (prim_ready),
    .instr_ready (instr_ready),
    .wr_en       (wr_en),
    .wr_slot     (wr_slot),
    .prim_valid  (prim_valid),
    .err_flag    (err_flag)
  );

  gs_emit_vbuf #(
    .VERT_W     (VERT_W),
    .PRIM_VERTS (PRIM_VERTS)
  ) u_vbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .wr_data   (out_regs),
    .prim_data (prim_data)
  );

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> $stable(prim_data));

  // R7
  prim_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_valid && !prim_ready) |=> $stable(prim_data));
endmodule

// File: tb/gs_emit_unit_tb_top.sv
`timescale 1ns/1ps
module gs_emit_unit_tb_top;
  localparam int VERT_W = 512;
  localparam int PRIM_W = 3 * VERT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              instr_valid = 1'b0;
  logic              instr_ready;
  logic [31:0]       instr_word = '0;
  logic [VERT_W-1:0] out_regs = '0;
  logic              prim_valid;
  logic              prim_ready = 1'b1;
  logic [PRIM_W-1:0] prim_data;
  logic              err_flag;

  int checks = 0;
  int fails  = 0;
  bit rdy_rand = 1'b0;

  logic [VERT_W-1:0] mbuf [4];
  logic [1:0]        m_slot;
  logic [1:0]        m_pf;
  bit                m_armed = 1'b0;
  bit                m_err = 1'b0;
  logic [PRIM_W-1:0] expq [$];

  always #2 clk = ~clk;

  gs_emit_unit dut_i (
    .clk (clk), .rst_n (rst_n),
    .instr_valid (instr_valid), .instr_ready (instr_ready),
    .instr_word (instr_word), .out_regs (out_regs),
    .prim_valid (prim_valid), .prim_ready (prim_ready),
    .prim_data (prim_data), .err_flag (err_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w_set(input logic [1:0] slot, input logic [1:0] pf,
                                        input logic [21:0] junk);
    return {6'h2B, slot, pf, junk};
  endfunction

  localparam logic [31:0] W_EMIT = {6'h2A, 26'h155_5555};

  task automatic new_regs();
    for (int j = 0; j < VERT_W / 32; j++) out_regs[j*32 +: 32] = $urandom;
  endtask

  task automatic send(input logic [31:0] w);
    @(posedge clk); #1;
    instr_valid = 1'b1;
    instr_word  = w;
    do @(negedge clk); while (!instr_ready);
    case (w[31:26])
      6'h2B: begin m_armed = 1'b1; m_slot = w[25:24]; m_pf = w[23:22]; end
      6'h2A: begin
        if (m_armed) begin
          m_armed = 1'b0;
          mbuf[m_slot] = out_regs;
          if (m_pf != 2'd0) expq.push_back({mbuf[2], mbuf[1], mbuf[0]});
        end else m_err = 1'b1;
      end
      default: ;
    endcase
    @(posedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic emit_to(input logic [1:0] slot, input logic [1:0] pf);
    new_regs();
    send(w_set(slot, pf, 22'(int'($urandom))));
    send(W_EMIT);
  endtask

  // Scoreboard monitor: R4, R5
  always @(negedge clk) begin
    if (rst_n && prim_valid && prim_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4", "unexpected primitive", 64'd1, 64'd0);
      end else begin
        logic [PRIM_W-1:0] e;
        e = expq.pop_front();
        for (int k = 0; k < 3; k++)
          chk(prim_data[k*VERT_W +: VERT_W] == e[k*VERT_W +: VERT_W], "R5",
              $sformatf("vertex %0d", k), prim_data[k*VERT_W +: 64], e[k*VERT_W +: 64]);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rdy_rand) prim_ready = 1'($urandom_range(0, 1));
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) mbuf[s] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(prim_valid == 1'b0, "R1", "prim_valid", 64'(prim_valid), 64'd0);
    chk(instr_ready == 1'b1, "R1", "instr_ready", 64'(instr_ready), 64'd1);
    chk(err_flag == 1'b0, "R1", "err_flag", 64'(err_flag), 64'd0);
    chk(prim_data == '0, "R1", "slots zero", prim_data[63:0], 64'd0);

    // R2 R3 R4: triangle, only the last emit has a nonzero flag
    emit_to(2'd0, 2'd0);
    emit_to(2'd1, 2'd0);
    @(negedge clk);
    chk(prim_valid == 1'b0, "R4", "zero flag raises nothing", 64'(prim_valid), 64'd0);
    emit_to(2'd2, 2'd1);
    // R6: strip reuse of slots 1 and 2
    emit_to(2'd0, 2'd2);
    // R11: the later slot-select wins
    new_regs();
    send(w_set(2'd1, 2'd0, 22'h0));
    send(w_set(2'd2, 2'd3, 22'h3FFFFF));
    send(W_EMIT);
    // R10: other opcodes leave the pending selection alone
    new_regs();
    send(w_set(2'd0, 2'd1, 22'h0));
    send(32'h0000_0000);
    send({6'h2C, 2'd3, 2'd0, 22'h12345});
    send({6'h13, 2'd2, 2'd2, 22'h0});
    send(W_EMIT);
    // R3: a slot 3 write leaves slots 0 to 2 as they were
    emit_to(2'd3, 2'd1);

    // R7 R8: stall while downstream not ready
    repeat (2) @(posedge clk);
    #1 prim_ready = 1'b0;
    emit_to(2'd1, 2'd1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(prim_valid == 1'b1, "R7", "held valid", 64'(prim_valid), 64'd1);
      chk(instr_ready == 1'b0, "R8", "stalled ready", 64'(instr_ready), 64'd0);
    end
    @(posedge clk); #1 prim_ready = 1'b1;
    @(negedge clk);
    chk(instr_ready == 1'b1, "R8", "ready with prim_ready", 64'(instr_ready), 64'd1);
    @(negedge clk);
    chk(prim_valid == 1'b0, "R7", "drop after handshake", 64'(prim_valid), 64'd0);
    chk(err_flag == 1'b0, "R9", "no error yet", 64'(err_flag), 64'd0);

    // R9: second emit without a fresh slot-select
    new_regs();
    send(W_EMIT);
    @(negedge clk);
    chk(err_flag == 1'b1, "R9", "error set", 64'(err_flag), 64'd1);

    // Mixed traffic under random back-pressure
    rdy_rand = 1'b1;
    for (int i = 0; i < 60; i++) begin
      emit_to(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 7) == 0) send(W_EMIT);
    end
    rdy_rand = 1'b0;
    @(posedge clk); #1 prim_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, "R4", "all primitives seen", 64'(expq.size()), 64'd0);
    chk(err_flag == m_err, "R9", "sticky error", 64'(err_flag), 64'(m_err));
    summary();
    $finish;
  end
endmodule